// File: doc/BRIEF.md
# Short-Loop Instruction Buffer

This block is a tiny instruction store placed between the fetch unit and the decoder of a simple in-order pipeline. Every instruction word returned by fetch is passed on to decode one cycle later. It is also written into a ring of `DEPTH` entries that always covers a contiguous run of word addresses: the most recently fetched sequential instructions. No training step is needed. A tight backward loop can be served from the ring the first time its closing branch is taken.

When the pipeline resolves a branch as taken, the target address is compared against the address run held in the ring. On a hit, `redirHit` rises in the same cycle, so the fetch unit can skip its own redirect. The target instruction then appears at the output on the next cycle, followed by its sequential successors, one per cycle, without touching instruction memory. When the newest stored word has been delivered, the block pulses `resumeValid` with the address that follows it and falls back to the fetch path. A miss leaves the fetch unit to redirect as usual, and the ring refills from the new stream. A flush empties the ring, for example after instruction memory has been written. The ring depth must be a power of two.

Top module: `loop_buffer`

## Requirements
- R1: After reset, `outValid` and `resumeValid` are low and the ring is empty, so any redirect misses.
- R2: A word accepted on the fetch port (`fetchValid` high, no redirect, no flush, not serving) appears on the outputs in the next cycle with `outFromBuf` = 0. Words keep their arrival order.
- R3: The ring holds at most `DEPTH` words (8 by default). Appending a sequential word to a full ring drops the oldest word, and a redirect to the dropped word misses.
- R4: A redirect to a word-aligned target inside the held address run raises `redirHit` in that cycle. The target instruction appears on the outputs in the next cycle with `outFromBuf` = 1.
- R5: While serving, the ring delivers one instruction per cycle at successive word addresses (step of 4 bytes).
- R6: In the cycle the newest held word is delivered from the ring, `resumeValid` is high and `resumeAddr` equals that word's address plus 4. The block then returns to the fetch path.
- R7: A redirect to a target outside the held run leaves `redirHit` low and produces no output in the next cycle.
- R8: A redirect target whose bits [1:0] are not 00 always misses.
- R9: Fetch-port words that arrive while the ring is serving are discarded. They change neither the delivered stream nor the ring contents.
- R10: After `flush`, there is no output in the next cycle and the ring is empty. If the ring was serving and no redirect came in the same cycle, `resumeValid` reports the next unread address.
- R11: A fetch word whose address is not the newest held address plus 4 restarts the ring, which then holds that single word.
- R12: A fetch word that arrives in the same cycle as a redirect is wrong-path and is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the ring |
| fetchValid | input | 1 | Fetch return valid |
| fetchAddr | input | AW | Byte address of returned word |
| fetchInstr | input | IW | Returned instruction word |
| redirValid | input | 1 | Taken-branch redirect |
| redirTarget | input | AW | Branch target byte address |
| redirHit | output | 1 | Target found in ring (same cycle) |
| outValid | output | 1 | Instruction to decode valid |
| outAddr | output | AW | Address of delivered instruction |
| outInstr | output | IW | Delivered instruction |
| outFromBuf | output | 1 | Delivered word came from the ring |
| resumeValid | output | 1 | Fetch should restart at resumeAddr |
| resumeAddr | output | AW | Restart address for fetch |

## Verification
The hardest state to reach from the ports is a ring whose head pointer has wrapped and whose oldest words were evicted while the address run stayed contiguous. In that state the target-to-slot mapping must add a word offset to a moved head. The stimulus streams well over `DEPTH` sequential words after a restart. It then loops over the full ring from its oldest surviving word, and it probes the first evicted address to confirm a miss. Flush in the middle of a loop and fetch returns arriving during serving are driven at chosen cycles, so that resume addresses and unchanged ring contents are observed.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

  // Strobes from control to datapath, at most one ring update per cycle.
  typedef struct packed {
    logic append;    // add fetched word after newest
    logic restart;   // ring holds only the fetched word
    logic clear;     // empty the ring
    logic outFetch;  // present fetched word to decode
    logic outBuf;    // present ring word to decode
  } lbufStrobe_t;

  typedef enum logic {
    MODE_FETCH = 1'b0,
    MODE_SERVE = 1'b1
  } lbufMode_t;

endpackage

// File: rtl/lbuf_store.sv
module lbuf_store
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int IW    = 32,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lbufStrobe_t       strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [IW-1:0]     wrInstr,
  input  logic [AW-1:0]     lookupAddr,
  input  logic [PTRW-1:0]   rdIdx,
  input  logic [AW-1:0]     rdAddr,
  output logic              lookupHit,
  output logic [PTRW-1:0]   lookupIdx,
  output logic [AW-1:0]     newestAddr,
  output logic              holdsAny,
  output logic              outValid,
  output logic [AW-1:0]     outAddr,
  output logic [IW-1:0]     outInstr,
  output logic              outFromBuf
);

  logic [IW-1:0]   slotInstr [DEPTH];
  logic [PTRW-1:0] headIdx;
  logic [CNTW-1:0] fill;
  logic [AW-1:0]   oldestAddr;
  logic [PTRW-1:0] tailIdx;
  logic [PTRW-1:0] wrIdx;
  logic            ringFull;
  logic            slotWrite;
  logic [AW-1:0]   wordOff;

  assign ringFull  = (fill == CNTW'(DEPTH));
  assign holdsAny  = (fill != '0);
  assign tailIdx   = headIdx + fill[PTRW-1:0];
  assign wrIdx     = strobe.restart ? '0 : tailIdx;
  assign slotWrite = strobe.append | strobe.restart;

  // One register per ring slot.
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [IW-1:0] word;
    always_ff @(posedge clk) begin
      if (slotWrite && wrIdx == PTRW'(g)) word <= wrInstr;
    end
    assign slotInstr[g] = word;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill       <= '0;
      headIdx    <= '0;
      oldestAddr <= '0;
    end else if (strobe.clear) begin
      fill       <= '0;
    end else if (strobe.restart) begin
      fill       <= CNTW'(1);
      headIdx    <= '0;
      oldestAddr <= wrAddr;
    end else if (strobe.append) begin
      if (ringFull) begin
        headIdx    <= headIdx + PTRW'(1);
        oldestAddr <= oldestAddr + AW'(4);
      end else begin
        fill <= fill + CNTW'(1);
      end
    end
  end

  // Address run lookup: target must be aligned and within [oldest, newest].
  assign newestAddr = oldestAddr + ((AW'(fill) - AW'(1)) << 2);
  assign wordOff    = (lookupAddr - oldestAddr) >> 2;
  assign lookupHit  = holdsAny && (lookupAddr[1:0] == 2'b00) &&
                      (lookupAddr >= oldestAddr) && (wordOff < AW'(fill));
  assign lookupIdx  = headIdx + wordOff[PTRW-1:0];

  // Output stage toward decode.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outAddr    <= '0;
      outInstr   <= '0;
      outFromBuf <= 1'b0;
    end else begin
      outValid <= strobe.outFetch | strobe.outBuf;
      if (strobe.outFetch) begin
        outAddr    <= wrAddr;
        outInstr   <= wrInstr;
        outFromBuf <= 1'b0;
      end else if (strobe.outBuf) begin
        outAddr    <= rdAddr;
        outInstr   <= slotInstr[rdIdx];
        outFromBuf <= 1'b1;
      end
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNTW'(DEPTH));

  assert_full_stays_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.append && ringFull |=> fill == CNTW'(DEPTH));

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !holdsAny);

  assert_restart_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart && !strobe.clear |=> fill == CNTW'(1) && oldestAddr == $past(wrAddr));

  assert_single_update_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.append, strobe.restart, strobe.clear}));

endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic            fetchValid,
  input  logic [AW-1:0]   fetchAddr,
  input  logic            redirValid,
  input  logic [AW-1:0]   redirTarget,
  input  logic            lookupHit,
  input  logic [PTRW-1:0] lookupIdx,
  input  logic [AW-1:0]   newestAddr,
  input  logic            holdsAny,
  output lbufStrobe_t     strobe,
  output logic [PTRW-1:0] rdIdx,
  output logic [AW-1:0]   rdAddr,
  output logic            resumeValid,
  output logic [AW-1:0]   resumeAddr
);

  lbufMode_t       mode, modeNext;
  logic [PTRW-1:0] readIdx, readIdxNext;
  logic [AW-1:0]   readAddr, readAddrNext;
  logic            resumeNext;
  logic [AW-1:0]   resumeAddrNext;

  always_comb begin
    strobe         = '0;
    rdIdx          = readIdx;
    rdAddr         = readAddr;
    modeNext       = mode;
    readIdxNext    = readIdx;
    readAddrNext   = readAddr;
    resumeNext     = 1'b0;
    resumeAddrNext = resumeAddr;

    if (flush) begin
      strobe.clear = 1'b1;
      modeNext     = MODE_FETCH;
      if (mode == MODE_SERVE && !redirValid) begin
        resumeNext     = 1'b1;
        resumeAddrNext = readAddr;
      end
    end else if (redirValid) begin
      // Fetch data in this cycle is wrong-path and is dropped.
      if (lookupHit) begin
        strobe.outBuf = 1'b1;
        rdIdx         = lookupIdx;
        rdAddr        = redirTarget;
        if (redirTarget == newestAddr) begin
          modeNext       = MODE_FETCH;
          resumeNext     = 1'b1;
          resumeAddrNext = redirTarget + AW'(4);
        end else begin
          modeNext     = MODE_SERVE;
          readIdxNext  = lookupIdx + PTRW'(1);
          readAddrNext = redirTarget + AW'(4);
        end
      end else begin
        modeNext = MODE_FETCH;
      end
    end else if (mode == MODE_SERVE) begin
      strobe.outBuf = 1'b1;
      if (readAddr == newestAddr) begin
        modeNext       = MODE_FETCH;
        resumeNext     = 1'b1;
        resumeAddrNext = readAddr + AW'(4);
      end else begin
        readIdxNext  = readIdx + PTRW'(1);
        readAddrNext = readAddr + AW'(4);
      end
    end else if (fetchValid) begin
      strobe.outFetch = 1'b1;
      if (holdsAny && fetchAddr == newestAddr + AW'(4)) strobe.append  = 1'b1;
      else                                             strobe.restart = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode        <= MODE_FETCH;
      readIdx     <= '0;
      readAddr    <= '0;
      resumeValid <= 1'b0;
      resumeAddr  <= '0;
    end else begin
      mode        <= modeNext;
      readIdx     <= readIdxNext;
      readAddr    <= readAddrNext;
      resumeValid <= resumeNext;
      resumeAddr  <= resumeAddrNext;
    end
  end

  // Serving never reads past the newest word and only runs on a filled ring.
  assert_serve_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    mode == MODE_SERVE |-> holdsAny && readAddr <= newestAddr);

  assert_serve_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    mode == MODE_SERVE && !flush |-> $stable(newestAddr));

endmodule

// File: rtl/loop_buffer.sv
module loop_buffer
  import lbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int IW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          fetchValid,
  input  logic [AW-1:0] fetchAddr,
  input  logic [IW-1:0] fetchInstr,
  input  logic          redirValid,
  input  logic [AW-1:0] redirTarget,
  output logic          redirHit,
  output logic          outValid,
  output logic [AW-1:0] outAddr,
  output logic [IW-1:0] outInstr,
  output logic          outFromBuf,
  output logic          resumeValid,
  output logic [AW-1:0] resumeAddr
);

  localparam int PTRW = $clog2(DEPTH);

  lbufStrobe_t     strobe;
  logic [PTRW-1:0] rdIdx, lookupIdx;
  logic [AW-1:0]   rdAddr, newestAddr;
  logic            lookupHit, holdsAny;

  lbuf_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk, .rstN, .flush, .fetchValid, .fetchAddr, .redirValid, .redirTarget,
    .lookupHit, .lookupIdx, .newestAddr, .holdsAny,
    .strobe, .rdIdx, .rdAddr, .resumeValid, .resumeAddr
  );

  lbuf_store #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_store (
    .clk, .rstN, .strobe,
    .wrAddr(fetchAddr), .wrInstr(fetchInstr), .lookupAddr(redirTarget),
    .rdIdx, .rdAddr, .lookupHit, .lookupIdx, .newestAddr, .holdsAny,
    .outValid, .outAddr, .outInstr, .outFromBuf
  );

  assign redirHit = redirValid && !flush && lookupHit;

  assert_hit_next_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    redirHit |=> outValid && outFromBuf && outAddr == $past(redirTarget));

  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    redirValid && !redirHit |=> !outValid);

  assert_unaligned_miss_R8: assert property (@(posedge clk) disable iff (!rstN)
    redirValid && redirTarget[1:0] != 2'b00 |-> !redirHit);

  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !outValid);

  assert_resume_after_newest_R6: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid && !$past(flush) |-> outValid && outFromBuf && resumeAddr == outAddr + AW'(4));

endmodule

// File: tb/loop_buffer_bench.sv
module loop_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic [31:0] fetchInstr = '0;
  logic        redirValid = 1'b0;
  logic [31:0] redirTarget = '0;
  logic        redirHit, outValid, outFromBuf, resumeValid;
  logic [31:0] outAddr, outInstr, resumeAddr;

  loop_buffer u_loop_buffer (
    .clk, .rstN, .flush, .fetchValid, .fetchAddr, .fetchInstr,
    .redirValid, .redirTarget, .redirHit, .outValid, .outAddr, .outInstr,
    .outFromBuf, .resumeValid, .resumeAddr
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] instr;
    logic        fromBuf;
    int          cyc;
    string       req;
  } outExp_t;

  typedef struct {
    logic [31:0] addr;
    int          cyc;
    string       req;
  } resExp_t;

  outExp_t outQ[$];
  resExp_t resQ[$];
  int checks = 0;
  int fails = 0;
  int cycleCnt = 0;
  bit finished = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic logic [31:0] instrOf(logic [31:0] a, logic [7:0] salt);
    return {salt, a[23:0]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: compare every produced item against the scoreboard.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid) begin
        if (outQ.size() == 0) begin
          check(1'b0, "R7", "unexpected output addr", {32'd0, outAddr}, 64'd0);
        end else begin
          outExp_t e;
          e = outQ.pop_front();
          check(outAddr == e.addr && outInstr == e.instr && outFromBuf == e.fromBuf && cycleCnt == e.cyc,
                e.req, "output {cyc,buf,addr}",
                {cycleCnt[22:0], outFromBuf, outAddr[7:0], outInstr},
                {e.cyc[22:0], e.fromBuf, e.addr[7:0], e.instr});
        end
      end
      if (resumeValid) begin
        if (resQ.size() == 0) begin
          check(1'b0, "R6", "unexpected resume addr", {32'd0, resumeAddr}, 64'd0);
        end else begin
          resExp_t r;
          r = resQ.pop_front();
          check(resumeAddr == r.addr && cycleCnt == r.cyc, r.req, "resume {cyc,addr}",
                {cycleCnt, resumeAddr}, {r.cyc, r.addr});
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Driver: sequential fetch returns, each expected one cycle later from fetch path.
  task automatic fetchRun(logic [31:0] a0, int n, logic [7:0] salt, string req);
    for (int i = 0; i < n; i++) begin
      outExp_t e;
      fetchValid = 1'b1;
      fetchAddr  = a0 + 32'(4 * i);
      fetchInstr = instrOf(fetchAddr, salt);
      e.addr = fetchAddr; e.instr = fetchInstr; e.fromBuf = 1'b0;
      e.cyc = cycleCnt + 1; e.req = req;
      outQ.push_back(e);
      tick();
    end
    fetchValid = 1'b0;
  endtask

  task automatic redirectHit(logic [31:0] target, logic [31:0] lastAddr, logic [7:0] salt,
                             bit withFetch, bit junk, string req);
    int n;
    resExp_t r;
    n = int'((lastAddr - target) >> 2) + 1;
    redirValid  = 1'b1;
    redirTarget = target;
    if (withFetch) begin  // R12: wrong-path fetch dropped
      fetchValid = 1'b1; fetchAddr = 32'h900; fetchInstr = 32'hDEAD0900;
    end
    for (int i = 0; i < n; i++) begin
      outExp_t e;
      e.addr = target + 32'(4 * i); e.instr = instrOf(e.addr, salt);
      e.fromBuf = 1'b1; e.cyc = cycleCnt + 1 + i; e.req = req;
      outQ.push_back(e);
    end
    r.addr = lastAddr + 32'd4; r.cyc = cycleCnt + n; r.req = "R6";
    resQ.push_back(r);
    #2;
    check(redirHit == 1'b1, "R4", "redirHit on hit", {63'd0, redirHit}, 64'd1);
    tick();
    redirValid = 1'b0;
    fetchValid = 1'b0;
    for (int i = 0; i < n - 1; i++) begin
      if (junk) begin  // R9: fetch returns while serving are ignored
        fetchValid = 1'b1; fetchAddr = 32'h500 + 32'(4 * i); fetchInstr = 32'hBAD00000;
      end
      tick();
    end
    fetchValid = 1'b0;
    idle(2);
  endtask

  task automatic redirectMiss(logic [31:0] target, bit withFetch, string req);
    redirValid  = 1'b1;
    redirTarget = target;
    if (withFetch) begin
      fetchValid = 1'b1; fetchAddr = 32'h904; fetchInstr = 32'hDEAD0904;
    end
    #2;
    check(redirHit == 1'b0, req, "redirHit on miss", {63'd0, redirHit}, 64'd0);
    tick();
    redirValid = 1'b0;
    fetchValid = 1'b0;
    idle(2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0 && resumeValid == 1'b0, "R1", "reset outputs",
          {62'd0, outValid, resumeValid}, 64'd0);
    rstN = 1'b1;
    tick();
    redirectMiss(32'h0, 1'b0, "R1");               // R1: empty ring misses

    fetchRun(32'h100, 8, 8'h11, "R2");              // R2: pass-through, fills ring
    idle(2);
    redirectHit(32'h100, 32'h11C, 8'h11, 1'b0, 1'b1, "R5");  // R4 R5 R6, junk fetch R9
    redirectHit(32'h100, 32'h11C, 8'h11, 1'b0, 1'b0, "R9");  // contents unchanged

    fetchRun(32'h120, 1, 8'h11, "R2");              // append to full ring, evicts 0x100
    idle(1);
    redirectMiss(32'h100, 1'b0, "R3");              // R3: evicted word misses
    redirectHit(32'h104, 32'h120, 8'h11, 1'b0, 1'b0, "R3");
    redirectMiss(32'h10A, 1'b0, "R8");              // R8: unaligned inside range
    redirectMiss(32'h124, 1'b0, "R7");              // R7: just past newest
    redirectHit(32'h118, 32'h120, 8'h11, 1'b0, 1'b0, "R4");
    redirectHit(32'h11C, 32'h120, 8'h11, 1'b1, 1'b0, "R12");
    redirectMiss(32'h200, 1'b1, "R12");             // R12: fetch with miss redirect dropped

    // R10: flush in the middle of serving
    begin
      resExp_t r;
      redirValid = 1'b1; redirTarget = 32'h104;
      for (int i = 0; i < 3; i++) begin
        outExp_t e;
        e.addr = 32'h104 + 32'(4 * i); e.instr = instrOf(e.addr, 8'h11);
        e.fromBuf = 1'b1; e.cyc = cycleCnt + 1 + i; e.req = "R10";
        outQ.push_back(e);
      end
      r.addr = 32'h110; r.cyc = cycleCnt + 4; r.req = "R10";
      resQ.push_back(r);
      tick();
      redirValid = 1'b0;
      idle(2);
      flush = 1'b1;
      tick();
      flush = 1'b0;
      idle(2);
    end
    redirectMiss(32'h108, 1'b0, "R10");             // R10: ring emptied

    fetchRun(32'h200, 4, 8'h22, "R2");
    fetchRun(32'h300, 3, 8'h22, "R11");             // R11: non-sequential restarts
    idle(1);
    redirectMiss(32'h200, 1'b0, "R11");
    redirectHit(32'h300, 32'h308, 8'h22, 1'b0, 1'b0, "R11");

    fetchRun(32'h30C, 10, 8'h22, "R2");             // wrap head: ring holds 0x314..0x330
    idle(1);
    redirectHit(32'h314, 32'h330, 8'h22, 1'b0, 1'b0, "R3");
    redirectMiss(32'h310, 1'b0, "R3");
    redirectHit(32'h330, 32'h330, 8'h22, 1'b0, 1'b0, "R6");  // newest only

    idle(3);
    check(outQ.size() == 0, "R5", "outputs outstanding", 64'(outQ.size()), 64'd0);
    check(resQ.size() == 0, "R6", "resumes outstanding", 64'(resQ.size()), 64'd0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule